// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block generates the raster timing for a video display: horizontal sync, vertical sync, data-enable, a blanking flag and an interlace field flag. Software sets the line and frame geometry through a small register port. Each register stores two timing fields. Some fields hold the value minus one and others hold the raw value, and the exact encoding is given in the requirements below. The pixel counter and the line counter run on the pixel clock. The register port shares that clock.

Software controls the block with two enables. The run enable starts the counters. The output enable lets sync and data-enable reach the pins. Software can set the polarity of each sync pulse. Entering vertical blank sets a status bit, and software clears that bit by writing one to it. The interrupt pin is driven only while this status bit and its enable bit are both set. Timing values written while a frame is in progress are held until the next frame starts. The counters always use the geometry that was loaded at the start of the current frame.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, all control bits and timing fields read as zero, data-enable is low, blank is high, and hsync, vsync, field and irq are all low.
- R2: A line lasts (HOR0[11:0] + 1) pixel clocks. Data-enable is high while the pixel index is at most HOR0[27:16] and the line index is at most VER0[27:16]. Otherwise blank is high.
- R3: The raw hsync pulse covers every pixel index p with HOR1[11:0] + 1 <= p < HOR1[27:16]. The start field is stored minus one and the end field is stored raw.
- R4: A frame lasts (VER0[11:0] + 1) lines. The raw vsync pulse covers every line index l with VER1[11:0] <= l < VER1[27:16]. Both fields are raw line numbers.
- R5: CTRL bit 3 inverts hsync and CTRL bit 4 inverts vsync. With the bit clear the pulse is active-high, and with it set the pulse is active-low.
- R6: The outputs need CTRL bit 0 (run) and CTRL bit 1 (output enable) both set. If either bit is clear, data-enable is low, blank is high and each sync sits at its inactive level. While run is clear, both counters are held at zero.
- R7: CTRL bit 6 (status) becomes set on the clock edge at which the counters leave the last pixel of the last active line. This happens whether or not CTRL bit 5 (interrupt enable) is set. irq equals status AND interrupt enable.
- R8: Writing one to CTRL bit 6 clears the status. Writing zero has no effect. If a clear and a new event fall on the same edge, the status stays set.
- R9: Timing register writes made while running take effect from the first pixel of the next frame. While run is clear, they take effect at once.
- R10: When CTRL bit 2 (interlace) is set at a frame start, the field flag toggles at that start. When it is clear, the field flag is forced to zero. In an odd field, the vsync decision for pixels below (HOR0[11:0] + 1) / 2 uses the previous line index, which delays vsync by half a line.
- R11: The register addresses are CTRL=0, HOR0=1, HOR1=2, VER0=3 and VER1=4. Each timing register reads back its fields at bits [11:0] and [27:16], with all other bits zero. CTRL reads back bits [6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, also clocks the register port |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (combinational) |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable |
| blank_o | output | 1 | Blanking flag |
| field_o | output | 1 | Interlace field flag (1 = odd field) |
| irq_o | output | 1 | Vertical blank interrupt |

## Verification
A pixel or line counter that wraps one count late or early shows up on hsync or data-enable within a single line. Over the following lines the error grows into a lasting phase slip, and vsync shows it by the next frame. If a timing field is decoded with the wrong encoding, a sync edge moves by exactly one pixel or one line. The bench compares the pins on every cycle, so it catches this on the first affected line. If the shadow copy is loaded at the wrong moment, or the status bit misses its set or clear, the effect appears within one frame: a change in line length before the frame boundary, or a status or irq value that is wrong when read back at the cycle of the event.

// File: rtl/rt_pkg.sv
package rt_pkg;
  parameter int unsigned TW     = 12;
  parameter int unsigned AW     = 3;
  parameter int unsigned DW     = 32;
  parameter int unsigned HI_LSB = 16;

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_HOR0 = AW'(1);
  localparam logic [AW-1:0] A_HOR1 = AW'(2);
  localparam logic [AW-1:0] A_VER0 = AW'(3);
  localparam logic [AW-1:0] A_VER1 = AW'(4);

  typedef struct packed {
    logic [TW-1:0] htot_m1;
    logic [TW-1:0] hact_m1;
    logic [TW-1:0] hs_beg_m1;
    logic [TW-1:0] hs_end;
    logic [TW-1:0] vtot_m1;
    logic [TW-1:0] vact_m1;
    logic [TW-1:0] vs_beg;
    logic [TW-1:0] vs_end;
  } timing_t;

  // bit 0 is run, bit 6 is status
  typedef struct packed {
    logic sts;
    logic ie;
    logic vneg;
    logic hneg;
    logic ilace;
    logic oen;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/rt_regs.sv
module rt_regs
  import rt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          vbl_evt_i,
  output logic [DW-1:0] rdata_o,
  output timing_t       cfg_o,
  output ctrl_t         ctrl_o
);
  localparam int unsigned CW = $bits(ctrl_t);

  logic [TW-1:0] lo_f, hi_f;
  logic          sts_clr;
  logic          unused_wdata;

  assign lo_f         = wdata_i[TW-1:0];
  assign hi_f         = wdata_i[HI_LSB +: TW];
  assign sts_clr      = wr_i && (addr_i == A_CTRL) && wdata_i[CW-1];
  assign unused_wdata = ^wdata_i;

  function automatic logic [DW-1:0] pack2(logic [TW-1:0] lo, logic [TW-1:0] hi);
    logic [DW-1:0] r;
    r = '0;
    r[TW-1:0]      = lo;
    r[HI_LSB +: TW] = hi;
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      cfg_o  <= '0;
    end else begin
      if (wr_i) begin
        unique case (addr_i)
          A_CTRL: begin
            ctrl_o.run   <= wdata_i[0];
            ctrl_o.oen   <= wdata_i[1];
            ctrl_o.ilace <= wdata_i[2];
            ctrl_o.hneg  <= wdata_i[3];
            ctrl_o.vneg  <= wdata_i[4];
            ctrl_o.ie    <= wdata_i[5];
          end
          A_HOR0: begin cfg_o.htot_m1   <= lo_f; cfg_o.hact_m1 <= hi_f; end
          A_HOR1: begin cfg_o.hs_beg_m1 <= lo_f; cfg_o.hs_end  <= hi_f; end
          A_VER0: begin cfg_o.vtot_m1   <= lo_f; cfg_o.vact_m1 <= hi_f; end
          A_VER1: begin cfg_o.vs_beg    <= lo_f; cfg_o.vs_end  <= hi_f; end
          default: ;
        endcase
      end
      // a new event wins over a simultaneous clear
      ctrl_o.sts <= vbl_evt_i | (ctrl_o.sts & ~sts_clr);
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = DW'(ctrl_o);
      A_HOR0:  rdata_o = pack2(cfg_o.htot_m1, cfg_o.hact_m1);
      A_HOR1:  rdata_o = pack2(cfg_o.hs_beg_m1, cfg_o.hs_end);
      A_VER0:  rdata_o = pack2(cfg_o.vtot_m1, cfg_o.vact_m1);
      A_VER1:  rdata_o = pack2(cfg_o.vs_beg, cfg_o.vs_end);
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rt_counter.sv
module rt_counter
  import rt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ilace_i,
  input  timing_t       cfg_i,
  output logic [TW-1:0] hcnt_o,
  output logic [TW-1:0] vcnt_o,
  output logic          field_o,
  output timing_t       wcfg_o,
  output logic          vbl_evt_o
);
  logic h_last, v_last;

  assign h_last    = hcnt_o == wcfg_o.htot_m1;
  assign v_last    = vcnt_o == wcfg_o.vtot_m1;
  assign vbl_evt_o = run_i && h_last && (vcnt_o == wcfg_o.vact_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_o  <= '0;
      vcnt_o  <= '0;
      field_o <= 1'b0;
      wcfg_o  <= '0;
    end else if (!run_i) begin
      hcnt_o  <= '0;
      vcnt_o  <= '0;
      field_o <= 1'b0;
      wcfg_o  <= cfg_i;
    end else if (h_last) begin
      hcnt_o <= '0;
      if (v_last) begin
        vcnt_o  <= '0;
        wcfg_o  <= cfg_i;
        field_o <= ilace_i & ~field_o;
      end else begin
        vcnt_o <= vcnt_o + 1'b1;
      end
    end else begin
      hcnt_o <= hcnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/rt_sync.sv
module rt_sync
  import rt_pkg::*;
(
  input  logic [TW-1:0] hcnt_i,
  input  logic [TW-1:0] vcnt_i,
  input  logic          field_i,
  input  timing_t       wcfg_i,
  input  ctrl_t         ctrl_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          blank_o
);
  logic [TW:0]   half;
  logic [TW-1:0] vprev, vline;
  logic          on, hs_raw, vs_raw, de_raw;

  assign half   = ({1'b0, wcfg_i.htot_m1} + 1'b1) >> 1;
  assign vprev  = (vcnt_i == '0) ? wcfg_i.vtot_m1 : vcnt_i - 1'b1;
  assign vline  = (field_i && ({1'b0, hcnt_i} < half)) ? vprev : vcnt_i;
  assign hs_raw = (hcnt_i > wcfg_i.hs_beg_m1) && (hcnt_i < wcfg_i.hs_end);
  assign vs_raw = (vline >= wcfg_i.vs_beg) && (vline < wcfg_i.vs_end);
  assign de_raw = (hcnt_i <= wcfg_i.hact_m1) && (vcnt_i <= wcfg_i.vact_m1);
  assign on     = ctrl_i.run && ctrl_i.oen;

  assign hsync_o = (hs_raw && on) ^ ctrl_i.hneg;
  assign vsync_o = (vs_raw && on) ^ ctrl_i.vneg;
  assign de_o    = de_raw && on;
  assign blank_o = ~de_o;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          blank_o,
  output logic          field_o,
  output logic          irq_o
);
  timing_t       cfg, wcfg;
  ctrl_t         ctrl;
  logic [TW-1:0] hcnt, vcnt;
  logic          vbl_evt;

  rt_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .vbl_evt_i(vbl_evt), .rdata_o, .cfg_o(cfg), .ctrl_o(ctrl)
  );

  rt_counter u_counter (
    .clk_i, .rst_ni, .run_i(ctrl.run), .ilace_i(ctrl.ilace), .cfg_i(cfg),
    .hcnt_o(hcnt), .vcnt_o(vcnt), .field_o, .wcfg_o(wcfg), .vbl_evt_o(vbl_evt)
  );

  rt_sync u_sync (
    .hcnt_i(hcnt), .vcnt_i(vcnt), .field_i(field_o), .wcfg_i(wcfg), .ctrl_i(ctrl),
    .hsync_o, .vsync_o, .de_o, .blank_o
  );

  assign irq_o = ctrl.sts & ctrl.ie;
endmodule

// File: rtl/rt_checker.sv
module rt_checker
  import rt_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input ctrl_t         ctrl,
  input timing_t       wcfg,
  input logic [TW-1:0] hcnt,
  input logic [TW-1:0] vcnt,
  input logic          field_o,
  input logic          de_o,
  input logic          blank_o,
  input logic          irq_o
);
  AST_OFF_NO_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl.run && ctrl.oen) |-> (!de_o && blank_o)); // R6
  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.run |=> (hcnt == '0 && vcnt == '0)); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.run |-> (hcnt <= wcfg.htot_m1 && vcnt <= wcfg.vtot_m1)); // R2
  AST_STS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl.sts) |-> $past(ctrl.run && hcnt == wcfg.htot_m1 && vcnt == wcfg.vact_m1)); // R7
  AST_IRQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl.ie); // R7
  AST_FIELD_AT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o != $past(field_o)) |-> (hcnt == '0 && vcnt == '0)); // R10
  AST_SHADOW_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.run && $past(ctrl.run) && !(hcnt == '0 && vcnt == '0)) |-> $stable(wcfg)); // R9
endmodule

bind raster_timing_gen rt_checker u_rt_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl(ctrl), .wcfg(wcfg), .hcnt(hcnt), .vcnt(vcnt),
  .field_o(field_o), .de_o(de_o), .blank_o(blank_o), .irq_o(irq_o)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        hsync_o, vsync_o, de_o, blank_o, field_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  raster_timing_gen u_raster_timing_gen (.*);

  // reference state
  bit m_run, m_oen, m_il, m_hn, m_vn, m_ie, m_sts;
  int unsigned p[4];
  int unsigned w[4];
  int m_h, m_v;
  bit m_f;
  bit [31:0] ctrl_w;

  function automatic int lo(int unsigned x); return int'(x & 32'hFFF); endfunction
  function automatic int hi(int unsigned x); return int'((x >> 16) & 32'hFFF); endfunction

  function automatic void model_step(bit wr, int addr, bit [31:0] d);
    int htm1, vtm1, vam1;
    bit evt;
    htm1 = lo(w[0]); vtm1 = lo(w[2]); vam1 = hi(w[2]);
    evt = m_run && m_h == htm1 && m_v == vam1;
    if (!m_run) begin
      m_h = 0; m_v = 0; m_f = 0; w = p;
    end else if (m_h == htm1) begin
      m_h = 0;
      if (m_v == vtm1) begin
        m_v = 0; w = p; m_f = m_il ? !m_f : 1'b0;
      end else m_v++;
    end else m_h++;
    if (wr && addr >= 1 && addr <= 4) p[addr-1] = d & 32'h0FFF0FFF;
    if (wr && addr == 0) begin
      m_run = d[0]; m_oen = d[1]; m_il = d[2]; m_hn = d[3]; m_vn = d[4]; m_ie = d[5];
    end
    m_sts = evt | (m_sts & !(wr && addr == 0 && d[6]));
  endfunction

  function automatic bit [31:0] ctrl_read();
    return {25'd0, m_sts, m_ie, m_vn, m_hn, m_il, m_oen, m_run};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (h=%0d v=%0d)", tag, what, act, exp, m_h, m_v);
    end
  endtask

  task automatic check_pins(string tag);
    int htm1, vtm1, half, vl;
    bit on, hs, vs, de;
    htm1 = lo(w[0]); vtm1 = lo(w[2]);
    on = m_run && m_oen;
    half = (htm1 + 1) / 2;
    vl = (m_f && m_h < half) ? ((m_v == 0) ? vtm1 : m_v - 1) : m_v;
    hs = (m_h >= lo(w[1]) + 1) && (m_h < hi(w[1]));
    vs = (vl >= lo(w[3])) && (vl < hi(w[3]));
    de = (m_h <= hi(w[0])) && (m_v <= hi(w[2])) && on;
    chk({tag, " R3/R5"}, "hsync", 32'(hsync_o), 32'((hs && on) ^ m_hn));
    chk({tag, " R4/R5/R10"}, "vsync", 32'(vsync_o), 32'((vs && on) ^ m_vn));
    chk({tag, " R2"}, "de", 32'(de_o), 32'(de));
    chk({tag, " R2/R6"}, "blank", 32'(blank_o), 32'(!de));
    chk({tag, " R10"}, "field", 32'(field_o), 32'(m_f));
    chk({tag, " R7"}, "irq", 32'(irq_o), 32'(m_sts && m_ie));
  endtask

  // one clock: drive at negedge, edge, update model, compare at next negedge
  task automatic tick(string tag, bit wr = 0, int addr = 0, bit [31:0] d = 0);
    wr_i = wr; addr_i = 3'(addr); wdata_i = d;
    @(posedge clk_i);
    model_step(wr, addr, d);
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = 3'd0;
    #1;
    check_pins(tag);
  endtask

  task automatic read_chk(string tag, int addr, bit [31:0] exp);
    addr_i = 3'(addr);
    #1;
    chk(tag, "rdata", rdata_o, exp);
  endtask

  task automatic run_cycles(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic write_ctrl(string tag, bit clr = 0);
    tick(tag, 1, 0, ctrl_w | (32'(clr) << 6));
  endtask

  task automatic program_random(string tag);
    int ht, ha, hsp, hse, vt, va, vss, vse;
    ht  = 10 + int'($urandom % 12);
    ha  = 2 + int'($urandom % (ht - 4));
    hsp = ha + 1 + int'($urandom % 2);
    hse = hsp + 1 + int'($urandom % 3);
    vt  = 6 + int'($urandom % 6);
    va  = 2 + int'($urandom % (vt - 4));
    vss = va + 1;
    vse = vss + 1 + int'($urandom % 2);
    tick(tag, 1, 1, 32'(((ha - 1) << 16) | (ht - 1)));
    tick(tag, 1, 2, 32'((hse << 16) | (hsp - 1)));
    tick(tag, 1, 3, 32'(((va - 1) << 16) | (vt - 1)));
    tick(tag, 1, 4, 32'((vse << 16) | vss));
  endtask

  function automatic int frame_len();
    return (lo(w[0]) + 1) * (lo(w[2]) + 1);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    m_run = 0; m_oen = 0; m_il = 0; m_hn = 0; m_vn = 0; m_ie = 0; m_sts = 0;
    p = '{default: 0}; w = '{default: 0}; m_h = 0; m_v = 0; m_f = 0;
    repeat (3) @(negedge clk_i);
    #1;
    // R1: reset state
    check_pins("R1");
    for (int a = 0; a < 5; a++) read_chk("R1", a, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11: readback of fields and control
    tick("R11", 1, 1, 32'hFFFF_ABCD);
    read_chk("R11", 1, 32'h0FFF_0BCD);
    tick("R11", 1, 2, 32'h1234_5678);
    read_chk("R11", 2, 32'h0234_0678);
    ctrl_w = 32'h0000_003C;
    write_ctrl("R11");
    read_chk("R11", 0, ctrl_read());
    read_chk("R11", 5, 32'd0);

    // R9: while stopped, writes load at once
    ctrl_w = 32'h0;
    write_ctrl("R9");
    program_random("R9");

    // random configurations with mid-frame reprogramming (R9)
    for (int i = 0; i < 6; i++) begin
      ctrl_w = 32'h23 | (32'($urandom % 8) << 2);
      write_ctrl("R2");
      if (i > 0) begin
        run_cycles("R9", int'($urandom % 40) + 3);
        program_random("R9");
      end
      run_cycles("R2/R3/R4", 3 * frame_len());
      read_chk("R7", 0, ctrl_read());
      if (i == 2 && m_sts) begin
        write_ctrl("R8", 1);
        read_chk("R8", 0, ctrl_read());
        chk("R8", "sts cleared", 32'(rdata_o[6]), 32'd0);
      end
      if (i == 3) begin
        write_ctrl("R8", 0);
        read_chk("R8", 0, ctrl_read());
      end
    end

    // R8: clear on same edge as event keeps status set
    while (!(m_h == lo(w[0]) && m_v == hi(w[2]))) tick("R8");
    write_ctrl("R8", 1);
    read_chk("R8", 0, ctrl_read());
    chk("R8", "set wins", 32'(rdata_o[6]), 32'd1);
    write_ctrl("R8", 1);
    read_chk("R8", 0, ctrl_read());

    // R7: status sets with interrupt disabled, irq stays low
    ctrl_w = 32'h03;
    write_ctrl("R7", 1);
    run_cycles("R7", frame_len() + 5);
    read_chk("R7", 0, ctrl_read());
    chk("R7", "sts no ie", 32'(rdata_o[6]), 32'd1);

    // R6: run without output enable, then stopped
    ctrl_w = 32'h19;
    write_ctrl("R6");
    run_cycles("R6", frame_len());
    ctrl_w = 32'h02;
    write_ctrl("R6");
    run_cycles("R6", 20);

    // R10: directed interlace with inverted syncs
    ctrl_w = 32'h3F;
    write_ctrl("R10");
    run_cycles("R10", 4 * frame_len());

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule